// File: doc/BRIEF.md
# Multiplexed Address/Data External Bus Controller

This block turns single-byte read and write requests from an internal processor-side port into cycles on an external bus. On that bus the low address byte and the data byte share one 8-bit path. The high address byte has its own dedicated 8-bit output, which gives a 64K-byte external space. An external transparent latch holds the low address byte while the address-latch strobe is high, and it freezes that byte when the strobe falls. The latch sits outside this block.

Each access runs through four timed phases, and each phase lasts a parameterised whole number of clock cycles (at least one):

- address setup, with the latch strobe high;
- address hold, after the latch strobe falls;
- strobe width, with the read or write strobe low;
- data hold, after the strobe returns high.

The shared bus appears at the top as a split pad: an output value, an output enable and an input value. An FPGA tristate buffer or the pad ring combines them.

Requests use a request/busy handshake, and only one access is in flight at a time. A one-cycle done pulse marks the end of the strobe. On a read, the captured data is valid in the same cycle as the done pulse. Every bus-facing output comes from a register.

Top module: `mxb_ctrl`

## Requirements
- R1: After reset: `ale` = 0, `rd_n` = 1, `wr_n` = 1, `ad_oe` = 0, `busy` = 0 and `done` = 0.
- R2: A request seen while idle is accepted at that clock edge. From the next cycle, for SETUP_CYC cycles:
  - `busy` = 1 and `ale` = 1;
  - `ad_oe` = 1 and `ad_out` = address bits [7:0];
  - `addr_hi` = address bits [15:8];
  - both strobes are high.
- R3: After setup, `ale` is 0 for ADDR_HOLD_CYC cycles. During those cycles `ad_out` still carries address bits [7:0], `ad_oe` = 1, and both strobes are high.
- R4: A write (`req_wr` = 1):
  - holds `wr_n` low for STROBE_CYC cycles;
  - drives `ad_out` = write byte with `ad_oe` = 1 during that time;
  - keeps driving the byte for DATA_HOLD_CYC cycles after `wr_n` rises.
- R5: A read (`req_wr` = 0) holds `rd_n` low for STROBE_CYC cycles. `ad_oe` = 0 for the whole strobe and hold period.
- R6: `rd_n` and `wr_n` are never low together, and neither is low while `ale` = 1.
- R7: `done` is high for exactly one cycle. That cycle is the first cycle after the strobe rises.
- R8: `rdata` equals the value on `ad_in` in the last cycle that `rd_n` is low. It is valid from the `done` cycle, even if `ad_in` changed earlier in the strobe.
- R9: `busy` falls after DATA_HOLD_CYC hold cycles. From then on `ad_oe` = 0.
- R10: A request raised while `busy` = 1 is ignored. No second access starts: `ale` stays 0 and `busy` stays 0 once the current access ends.
- R11: `addr_hi` stays stable from the cycle after acceptance until the next accepted request.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| req | input | 1 | Access request, taken when idle |
| req_wr | input | 1 | 1 = write, 0 = read |
| req_addr | input | 16 | Byte address |
| req_wdata | input | 8 | Write byte |
| busy | output | 1 | Access in progress |
| done | output | 1 | One-cycle end-of-strobe pulse |
| rdata | output | 8 | Byte captured on the last read |
| addr_hi | output | 8 | High address byte |
| ale | output | 1 | Address latch enable, active high |
| rd_n | output | 1 | Read strobe, active low |
| wr_n | output | 1 | Write strobe, active low |
| ad_out | output | 8 | Shared bus drive value |
| ad_oe | output | 1 | Shared bus output enable |
| ad_in | input | 8 | Shared bus sampled value |

## Verification
A request is accepted at a clock edge, and each access output then changes exactly one cycle later, because the outputs are registered from the next state. The phase boundaries therefore fall after SETUP_CYC, then ADDR_HOLD_CYC, then STROBE_CYC, then DATA_HOLD_CYC cycles from acceptance. `done` and `rdata` appear in the first hold cycle, and `busy` falls one cycle after the last hold cycle. The directed tasks step on falling clock edges and check every output in every cycle against this counted schedule, so an access that is one cycle early or late is caught. The bench drives `ad_in` on falling edges, with a different value in each strobe cycle, which shows which edge the read capture uses.

// File: rtl/mxb_pkg.sv
package mxb_pkg;
  typedef enum logic [2:0] {
    PH_IDLE  = 3'd0,
    PH_SETUP = 3'd1,
    PH_AHOLD = 3'd2,
    PH_STRB  = 3'd3,
    PH_DHOLD = 3'd4
  } mxb_phase_e;
endpackage

// File: rtl/mxb_phase_timer.sv
module mxb_phase_timer #(
  parameter int CNT_W = 4
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             load,
  input  logic [CNT_W-1:0] load_val,
  output logic             last
);
  logic [CNT_W-1:0] cnt_q;

  always_ff @(posedge clk) begin
    if (rst)                 cnt_q <= '0;
    else if (load)           cnt_q <= load_val;
    else if (cnt_q != '0)    cnt_q <= cnt_q - 1'b1;
  end

  assign last = (cnt_q == '0);
endmodule

// File: rtl/mxb_seq.sv
module mxb_seq
  import mxb_pkg::*;
#(
  parameter int SETUP_CYC     = 2,
  parameter int ADDR_HOLD_CYC = 1,
  parameter int STROBE_CYC    = 3,
  parameter int DATA_HOLD_CYC = 1
) (
  input  logic       clk,
  input  logic       rst,
  input  logic       req,
  input  logic       wr_sel,
  input  logic [7:0] alo_sel,
  input  logic [7:0] wdat_sel,
  output logic       accept,
  output logic       capture,
  output logic       busy,
  output logic       done,
  output logic       ale,
  output logic       rd_n,
  output logic       wr_n,
  output logic [7:0] ad_out,
  output logic       ad_oe
);
  localparam int MAXA  = (SETUP_CYC > ADDR_HOLD_CYC) ? SETUP_CYC : ADDR_HOLD_CYC;
  localparam int MAXB  = (STROBE_CYC > DATA_HOLD_CYC) ? STROBE_CYC : DATA_HOLD_CYC;
  localparam int MAXL  = (MAXA > MAXB) ? MAXA : MAXB;
  localparam int CNT_W = (MAXL < 2) ? 1 : $clog2(MAXL);

  localparam logic [CNT_W-1:0] LD_SETUP = CNT_W'(SETUP_CYC - 1);
  localparam logic [CNT_W-1:0] LD_AHOLD = CNT_W'(ADDR_HOLD_CYC - 1);
  localparam logic [CNT_W-1:0] LD_STRB  = CNT_W'(STROBE_CYC - 1);
  localparam logic [CNT_W-1:0] LD_DHOLD = CNT_W'(DATA_HOLD_CYC - 1);

  mxb_phase_e       ph_q, ph_d;
  logic             t_last, t_load;
  logic [CNT_W-1:0] t_val;
  logic             wr_q;

  mxb_phase_timer #(.CNT_W(CNT_W)) u_timer (
    .clk(clk), .rst(rst), .load(t_load), .load_val(t_val), .last(t_last)
  );

  always_comb begin
    ph_d   = ph_q;
    t_load = 1'b0;
    t_val  = '0;
    unique case (ph_q)
      PH_IDLE:  if (req)    begin ph_d = PH_SETUP; t_load = 1'b1; t_val = LD_SETUP; end
      PH_SETUP: if (t_last) begin ph_d = PH_AHOLD; t_load = 1'b1; t_val = LD_AHOLD; end
      PH_AHOLD: if (t_last) begin ph_d = PH_STRB;  t_load = 1'b1; t_val = LD_STRB;  end
      PH_STRB:  if (t_last) begin ph_d = PH_DHOLD; t_load = 1'b1; t_val = LD_DHOLD; end
      PH_DHOLD: if (t_last)       ph_d = PH_IDLE;
      default:                    ph_d = PH_IDLE;
    endcase
  end

  assign accept  = (ph_q == PH_IDLE) && req;
  assign capture = (ph_q == PH_STRB) && t_last && !wr_q;

  always_ff @(posedge clk) begin
    if (rst) begin
      ph_q   <= PH_IDLE;
      wr_q   <= 1'b0;
      busy   <= 1'b0;
      done   <= 1'b0;
      ale    <= 1'b0;
      rd_n   <= 1'b1;
      wr_n   <= 1'b1;
      ad_out <= '0;
      ad_oe  <= 1'b0;
    end else begin
      ph_q   <= ph_d;
      wr_q   <= wr_sel;
      busy   <= (ph_d != PH_IDLE);
      done   <= (ph_q == PH_STRB) && t_last;
      ale    <= (ph_d == PH_SETUP);
      rd_n   <= !((ph_d == PH_STRB) && !wr_sel);
      wr_n   <= !((ph_d == PH_STRB) && wr_sel);
      ad_out <= ((ph_d == PH_SETUP) || (ph_d == PH_AHOLD)) ? alo_sel : wdat_sel;
      ad_oe  <= (ph_d == PH_SETUP) || (ph_d == PH_AHOLD) ||
                (((ph_d == PH_STRB) || (ph_d == PH_DHOLD)) && wr_sel);
    end
  end

  AST_STROBE_EXCL: assert property (@(posedge clk) disable iff (rst)
    !(!rd_n && !wr_n)); // R6
  AST_NO_STROBE_WITH_ALE: assert property (@(posedge clk) disable iff (rst)
    ale |-> (rd_n && wr_n)); // R6
  AST_ALE_FALL_HOLD: assert property (@(posedge clk) disable iff (rst)
    $fell(ale) |-> (rd_n && wr_n && ad_oe)); // R3
  AST_READ_RELEASED: assert property (@(posedge clk) disable iff (rst)
    !rd_n |-> !ad_oe); // R5
  AST_WRITE_DRIVEN: assert property (@(posedge clk) disable iff (rst)
    !wr_n |-> ad_oe); // R4
  AST_DONE_SINGLE: assert property (@(posedge clk) disable iff (rst)
    done |=> !done); // R7
  AST_DONE_AFTER_STROBE: assert property (@(posedge clk) disable iff (rst)
    done |-> (rd_n && wr_n && busy)); // R7
  AST_BUSY_FALL_RELEASE: assert property (@(posedge clk) disable iff (rst)
    $fell(busy) |-> !ad_oe); // R9
endmodule

// File: rtl/mxb_ctrl.sv
module mxb_ctrl #(
  parameter int SETUP_CYC     = 2,
  parameter int ADDR_HOLD_CYC = 1,
  parameter int STROBE_CYC    = 3,
  parameter int DATA_HOLD_CYC = 1,
  parameter int AW            = 16,
  parameter int DW            = 8
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          req,
  input  logic          req_wr,
  input  logic [AW-1:0] req_addr,
  input  logic [DW-1:0] req_wdata,
  output logic          busy,
  output logic          done,
  output logic [DW-1:0] rdata,
  output logic [AW-DW-1:0] addr_hi,
  output logic          ale,
  output logic          rd_n,
  output logic          wr_n,
  output logic [DW-1:0] ad_out,
  output logic          ad_oe,
  input  logic [DW-1:0] ad_in
);
  logic          accept, capture;
  logic          wr_q;
  logic [AW-1:0] addr_q;
  logic [DW-1:0] wdat_q;
  logic          wr_sel;
  logic [AW-1:0] addr_sel;
  logic [DW-1:0] wdat_sel;

  assign wr_sel   = accept ? req_wr    : wr_q;
  assign addr_sel = accept ? req_addr  : addr_q;
  assign wdat_sel = accept ? req_wdata : wdat_q;

  always_ff @(posedge clk) begin
    if (rst) begin
      wr_q   <= 1'b0;
      addr_q <= '0;
      wdat_q <= '0;
      rdata  <= '0;
    end else begin
      wr_q   <= wr_sel;
      addr_q <= addr_sel;
      wdat_q <= wdat_sel;
      if (capture) rdata <= ad_in;
    end
  end

  assign addr_hi = addr_q[AW-1:DW];

  mxb_seq #(
    .SETUP_CYC(SETUP_CYC), .ADDR_HOLD_CYC(ADDR_HOLD_CYC),
    .STROBE_CYC(STROBE_CYC), .DATA_HOLD_CYC(DATA_HOLD_CYC)
  ) u_seq (
    .clk(clk), .rst(rst), .req(req), .wr_sel(wr_sel),
    .alo_sel(addr_sel[DW-1:0]), .wdat_sel(wdat_sel),
    .accept(accept), .capture(capture), .busy(busy), .done(done),
    .ale(ale), .rd_n(rd_n), .wr_n(wr_n), .ad_out(ad_out), .ad_oe(ad_oe)
  );

  AST_ADDR_HI_STABLE: assert property (@(posedge clk) disable iff (rst)
    busy |=> $stable(addr_hi)); // R11
  AST_IGNORE_WHILE_BUSY: assert property (@(posedge clk) disable iff (rst)
    (busy && req) |-> !accept); // R10
  AST_RDATA_ONLY_ON_DONE: assert property (@(posedge clk) disable iff (rst)
    !$stable(rdata) |-> done); // R8
endmodule

// File: tb/mxb_ctrl_tb.sv
module mxb_ctrl_tb;
  localparam int S = 2, H = 2, W = 3, D = 2;

  logic       clk = 1'b0;
  logic       rst = 1'b1;
  logic       req = 1'b0, req_wr = 1'b0;
  logic [15:0] req_addr = '0;
  logic [7:0] req_wdata = '0, ad_in = '0;
  logic       busy, done, ale, rd_n, wr_n, ad_oe;
  logic [7:0] rdata, addr_hi, ad_out;
  int total = 0, bad = 0;
  bit finished = 1'b0;

  always #5 clk = ~clk;

  mxb_ctrl #(.SETUP_CYC(S), .ADDR_HOLD_CYC(H), .STROBE_CYC(W), .DATA_HOLD_CYC(D)) u_dut (
    .clk(clk), .rst(rst), .req(req), .req_wr(req_wr), .req_addr(req_addr),
    .req_wdata(req_wdata), .busy(busy), .done(done), .rdata(rdata),
    .addr_hi(addr_hi), .ale(ale), .rd_n(rd_n), .wr_n(wr_n),
    .ad_out(ad_out), .ad_oe(ad_oe), .ad_in(ad_in)
  );

  task automatic chk(input bit ok, input string tag, input logic [31:0] act, input logic [31:0] exp);
    total++;
    if (!ok) begin
      bad++;
      $display("FAIL %s actual=%0h expected=%0h at %0t", tag, act, exp, $time);
    end
  endtask

  task automatic test_reset();
    @(negedge clk);
    chk(ale == 1'b0, "R1 ale", ale, 0);
    chk(rd_n && wr_n, "R1 strobes", {rd_n, wr_n}, 3);
    chk(ad_oe == 1'b0, "R1 oe", ad_oe, 0);
    chk(!busy && !done, "R1 busy/done", {busy, done}, 0);
  endtask

  task automatic start(input bit w, input logic [15:0] a, input logic [7:0] d);
    @(negedge clk);
    req = 1'b1; req_wr = w; req_addr = a; req_wdata = d;
    @(negedge clk);
    req = 1'b0; req_addr = 16'hFFFF; req_wdata = 8'h00; req_wr = ~w;
  endtask

  task automatic addr_phases(input logic [15:0] a);
    for (int i = 0; i < S; i++) begin
      chk(ale && busy, "R2 ale/busy", {ale, busy}, 3);
      chk(ad_oe && ad_out == a[7:0], "R2 low addr", ad_out, a[7:0]);
      chk(addr_hi == a[15:8], "R2 high addr", addr_hi, a[15:8]);
      chk(rd_n && wr_n, "R6 strobes high with ale", {rd_n, wr_n}, 3);
      @(negedge clk);
    end
    for (int i = 0; i < H; i++) begin
      chk(!ale && ad_oe && ad_out == a[7:0], "R3 addr hold", {ale, ad_oe, ad_out}, {2'b01, a[7:0]});
      chk(rd_n && wr_n, "R3 strobes high", {rd_n, wr_n}, 3);
      chk(addr_hi == a[15:8], "R11 high addr", addr_hi, a[15:8]);
      @(negedge clk);
    end
  endtask

  task automatic test_write(input logic [15:0] a, input logic [7:0] d);
    start(1'b1, a, d);
    addr_phases(a);
    for (int i = 0; i < W; i++) begin
      chk(!wr_n && rd_n, "R4 wr strobe", {rd_n, wr_n}, 2);
      chk(ad_oe && ad_out == d, "R4 write data", ad_out, d);
      chk(!done, "R7 no early done", done, 0);
      @(negedge clk);
    end
    for (int i = 0; i < D; i++) begin
      chk(done == (i == 0), "R7 done pulse", done, (i == 0));
      chk(wr_n && ad_oe && ad_out == d, "R4 data hold", {wr_n, ad_oe, ad_out}, {2'b11, d});
      chk(busy && addr_hi == a[15:8], "R11 busy/addr", {busy, addr_hi}, {1'b1, a[15:8]});
      @(negedge clk);
    end
    chk(!busy && !ad_oe && !done, "R9 idle after hold", {busy, ad_oe, done}, 0);
  endtask

  task automatic test_read(input logic [15:0] a, input logic [7:0] base);
    start(1'b0, a, 8'h00);
    addr_phases(a);
    for (int i = 0; i < W; i++) begin
      ad_in = base + 8'(i);
      chk(!rd_n && wr_n, "R5 rd strobe", {rd_n, wr_n}, 1);
      chk(!ad_oe, "R5 bus released", ad_oe, 0);
      @(negedge clk);
    end
    ad_in = 8'hEE;
    for (int i = 0; i < D; i++) begin
      chk(done == (i == 0), "R7 done pulse", done, (i == 0));
      chk(rdata == base + 8'(W - 1), "R8 read capture", rdata, base + 8'(W - 1));
      chk(rd_n && !ad_oe, "R5 hold released", {rd_n, ad_oe}, 2);
      @(negedge clk);
    end
    chk(!busy, "R9 busy low", busy, 0);
    chk(rdata == base + 8'(W - 1), "R8 rdata kept", rdata, base + 8'(W - 1));
  endtask

  task automatic test_busy_ignore(input logic [15:0] a);
    start(1'b1, a, 8'h3C);
    req = 1'b1; req_addr = 16'h1234; req_wr = 1'b0;
    @(negedge clk);
    @(negedge clk);
    req = 1'b0;
    repeat (S + H + W + D - 2) @(negedge clk);
    chk(!busy, "R10 access ended", busy, 0);
    for (int i = 0; i < 3; i++) begin
      chk(!ale && !busy, "R10 no second access", {ale, busy}, 0);
      chk(addr_hi == a[15:8], "R10 high addr unchanged", addr_hi, a[15:8]);
      @(negedge clk);
    end
  endtask

  initial begin
    repeat (3) @(posedge clk);
    rst = 1'b0;
    test_reset();
    test_write(16'hA55A, 8'hC3);
    test_read(16'h7F01, 8'h40);
    test_write(16'h00FF, 8'h00);
    test_read(16'hFF00, 8'hFD);
    test_busy_ignore(16'hBE12);
    finished = 1'b1;
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!finished) begin
      total++; bad++;
      $display("FAIL watchdog actual=1 expected=0");
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end
endmodule